// File: doc/BRIEF.md
# Restoring Sequential Integer Divider with HI/LO Result

This block divides one integer by another over many clock cycles and uses a single subtractor for the whole job. A one-cycle `start` pulse loads a dividend, a divisor and a mode bit that selects signed or unsigned operation. The block then produces one quotient bit per cycle using restoring division. The remainder and quotient live together in one register pair that shifts left on every step. After the last step, the remainder is written to `hi` and the quotient to `lo`, and `done` pulses for one cycle.

In signed mode the block divides the magnitudes of the operands and fixes the signs afterwards. The quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. No condition is flagged in any case. A zero divisor runs through the same steps and gives a fixed, predictable result. The most-negative-divided-by-minus-one case wraps with no flag.

Top module: `div_restoring_hilo`

## Requirements
- R1: When `busy` is 0, a `start` high at a rising edge captures `dividend`, `divisor` and `is_signed`, and `busy` is 1 from the next cycle on.
- R2: `done` is high for exactly one cycle. It rises at the WIDTH-th rising edge after the edge that accepted `start`, and `busy` drops at that same edge.
- R3: In unsigned mode (`is_signed`=0) with a nonzero divisor, `lo` holds the quotient and `hi` the remainder, with lo*divisor + hi = dividend and hi < divisor.
- R4: In signed mode (`is_signed`=1, operands in two's complement) with a nonzero divisor, the quotient rounds toward zero. It is negative when the operand signs differ, and the remainder carries the dividend's sign.
- R5: In signed mode, the most negative dividend divided by -1 gives `lo` equal to the most negative value and `hi` equal to 0, with no flag.
- R6: In unsigned mode with divisor 0, `hi` equals the dividend and `lo` is all ones.
- R7: In signed mode with divisor 0, `hi` equals the dividend. `lo` is all ones for a non-negative dividend and 1 for a negative one.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running operation keeps its operands and its completion cycle.
- R9: Reset clears `hi`, `lo`, `done` and `busy`. Between completions, `hi` and `lo` keep their last values.
- R10: With WIDTH=4, 6 divided by 2 in either mode gives quotient 3 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Number to be divided |
| divisor | input | WIDTH | Number to divide by |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are written |
| hi | output | WIDTH | Remainder of the last division |
| lo | output | WIDTH | Quotient of the last division |

## Verification
The bench builds two copies of the block. One uses WIDTH=4, so every dividend and divisor pair can be swept in both modes. That sweep covers zero divisors, the most negative value over -1, and all sign mixes, each checked against arithmetic in the bench. The second copy keeps WIDTH=32 and runs directed cases at the full width: large unsigned values, sign mixes, the wrap case and zero divisors. It confirms that the counter and the width-dependent logic scale correctly.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic quo_neg;
    logic rem_neg;
  } sign_fix_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic                 mode_signed,
  input  logic [WIDTH-1:0]     num_in,
  input  logic [WIDTH-1:0]     den_in,
  output logic [WIDTH-1:0]     num_mag,
  output logic [WIDTH-1:0]     den_mag,
  output div_pkg::sign_fix_t   fix
);
  localparam int MSB = WIDTH - 1;

  logic num_neg, den_neg;

  always_comb begin
    num_neg     = mode_signed & num_in[MSB];
    den_neg     = mode_signed & den_in[MSB];
    num_mag     = num_neg ? (~num_in + 1'b1) : num_in;
    den_mag     = den_neg ? (~den_in + 1'b1) : den_in;
    fix.quo_neg = num_neg ^ den_neg;
    fix.rem_neg = num_neg;
  end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] part_rem,
  input  logic [WIDTH-1:0] part_quo,
  input  logic [WIDTH-1:0] den,
  output logic [WIDTH-1:0] next_rem,
  output logic [WIDTH-1:0] next_quo
);
  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] trial;
  logic             went_neg;

  always_comb begin
    shifted  = {part_rem, part_quo[WIDTH-1]};
    trial    = {1'b0, shifted} - {2'b00, den};
    went_neg = trial[WIDTH+1];
    // a negative trial restores the value held before the subtraction
    next_rem = went_neg ? shifted[WIDTH-1:0] : trial[WIDTH-1:0];
    next_quo = {part_quo[WIDTH-2:0], ~went_neg};
  end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int WIDTH = 32
) (
  input  div_pkg::sign_fix_t fix,
  input  logic [WIDTH-1:0]   quo_mag,
  input  logic [WIDTH-1:0]   rem_mag,
  output logic [WIDTH-1:0]   quo_out,
  output logic [WIDTH-1:0]   rem_out
);
  always_comb begin
    quo_out = fix.quo_neg ? (~quo_mag + 1'b1) : quo_mag;
    rem_out = fix.rem_neg ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/div_restoring_hilo.sv
module div_restoring_hilo #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  div_pkg::sign_fix_t fix_in, fix_q;
  logic [WIDTH-1:0] mag_num, mag_den;
  logic [WIDTH-1:0] rem_q, quo_q, den_q;
  logic [WIDTH-1:0] rem_nx, quo_nx;
  logic [WIDTH-1:0] quo_fixed, rem_fixed;
  logic [CNT_W-1:0] step_cnt;
  logic             busy_q, done_q;
  logic [WIDTH-1:0] hi_q, lo_q;
  logic             accept;

  div_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .mode_signed (is_signed),
    .num_in      (dividend),
    .den_in      (divisor),
    .num_mag     (mag_num),
    .den_mag     (mag_den),
    .fix         (fix_in)
  );

  div_restore_step #(.WIDTH(WIDTH)) u_step (
    .part_rem (rem_q),
    .part_quo (quo_q),
    .den      (den_q),
    .next_rem (rem_nx),
    .next_quo (quo_nx)
  );

  div_result_fix #(.WIDTH(WIDTH)) u_fix (
    .fix     (fix_q),
    .quo_mag (quo_nx),
    .rem_mag (rem_nx),
    .quo_out (quo_fixed),
    .rem_out (rem_fixed)
  );

  assign accept = start & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      step_cnt <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      den_q    <= '0;
      fix_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        step_cnt <= '0;
        rem_q    <= '0;
        quo_q    <= mag_num;
        den_q    <= mag_den;
        fix_q    <= fix_in;
      end else if (busy_q) begin
        rem_q    <= rem_nx;
        quo_q    <= quo_nx;
        step_cnt <= step_cnt + 1'b1;
        if (step_cnt == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= rem_fixed;
          lo_q   <= quo_fixed;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/div_hilo_checker.sv
module div_hilo_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             is_signed,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo
);
  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0]      since;
  logic [WIDTH-1:0]   cap_a, cap_b;
  logic               cap_s;
  logic [2*WIDTH-1:0] rebuilt;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      cap_a <= '0;
      cap_b <= '0;
      cap_s <= 1'b0;
    end else if (start && !busy) begin
      since <= '0;
      cap_a <= dividend;
      cap_b <= divisor;
      cap_s <= is_signed;
    end else if (busy) begin
      since <= since + 1'b1;
    end
  end

  always_comb begin
    rebuilt = {{WIDTH{1'b0}}, lo} * {{WIDTH{1'b0}}, cap_b} + {{WIDTH{1'b0}}, hi};
  end

  a_r1_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (since == CW'(WIDTH) && !busy));

  a_r3_identity: assert property (@(posedge clk) disable iff (rst)
    (done && !cap_s && cap_b != '0) |->
      (rebuilt == {{WIDTH{1'b0}}, cap_a} && hi < cap_b));

  a_r6_zero_unsigned: assert property (@(posedge clk) disable iff (rst)
    (done && !cap_s && cap_b == '0) |-> (hi == cap_a && lo == '1));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(hi) && $stable(lo)));
endmodule

bind div_restoring_hilo div_hilo_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .is_signed (is_signed),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .hi        (hi),
  .lo        (lo)
);

// File: tb/test_div_restoring_hilo.sv
module test_div_restoring_hilo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        st4 = 1'b0, sg4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0, hi4, lo4;
  logic        busy4, done4;
  logic        st32 = 1'b0, sg32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0, hi32, lo32;
  logic        busy32, done32;

  div_restoring_hilo #(.WIDTH(4)) i_div_restoring_hilo (
    .clk(clk), .rst(rst), .start(st4), .is_signed(sg4),
    .dividend(a4), .divisor(b4), .busy(busy4), .done(done4),
    .hi(hi4), .lo(lo4));

  div_restoring_hilo #(.WIDTH(32)) i_div_restoring_hilo_w32 (
    .clk(clk), .rst(rst), .start(st32), .is_signed(sg32),
    .dividend(a32), .divisor(b32), .busy(busy32), .done(done32),
    .hi(hi32), .lo(lo32));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input int w, input longint a, input longint b, input bit s,
                                output longint q, output longint r);
    longint m, sa, sb;
    m  = (64'sd1 <<< w) - 1;
    sa = (s && a[w-1]) ? a - (64'sd1 <<< w) : a;
    sb = (s && b[w-1]) ? b - (64'sd1 <<< w) : b;
    if (b == 0) begin
      r = a;
      q = (s && a[w-1]) ? 64'sd1 : m;
    end else if (s) begin
      q = (sa / sb) & m;
      r = (sa % sb) & m;
    end else begin
      q = a / b;
      r = a % b;
    end
  endfunction

  function automatic string tag_for(input int w, input longint a, input longint b, input bit s);
    if (b == 0) return s ? "R7" : "R6";
    if (s && a == (64'sd1 <<< (w-1)) && b == ((64'sd1 <<< w) - 1)) return "R5";
    return s ? "R4" : "R3";
  endfunction

  task automatic op4(input logic [3:0] a, input logic [3:0] b, input bit s, input bit intf);
    longint q, r;
    bit early = 1'b0;
    @(negedge clk);
    st4 = 1'b1; a4 = a; b4 = b; sg4 = s;
    @(negedge clk);
    st4 = 1'b0;
    chk(busy4 === 1'b1, "R1 busy after accept", 64'(busy4), 64'd1);
    for (int k = 1; k <= 4; k++) begin
      if (intf && k == 1) begin st4 = 1'b1; a4 = 4'd7; b4 = 4'd2; sg4 = 1'b0; end
      @(negedge clk);
      if (intf && k == 1) st4 = 1'b0;
      if (k < 4 && done4 !== 1'b0) early = 1'b1;
    end
    chk(!early && done4 === 1'b1 && busy4 === 1'b0, "R2 done timing", {early, done4, busy4}, 64'b010);
    model(4, longint'(a), longint'(b), s, q, r);
    chk({hi4, lo4} === {r[3:0], q[3:0]}, intf ? "R8 start while busy" : tag_for(4, longint'(a), longint'(b), s),
        {a, b, hi4, lo4}, {a, b, r[3:0], q[3:0]});
    @(negedge clk);
    chk(done4 === 1'b0, "R2 done single cycle", 64'(done4), 64'd0);
  endtask

  task automatic op32(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint q, r;
    bit early = 1'b0;
    @(negedge clk);
    st32 = 1'b1; a32 = a; b32 = b; sg32 = s;
    @(negedge clk);
    st32 = 1'b0;
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (k < 32 && done32 !== 1'b0) early = 1'b1;
    end
    chk(!early && done32 === 1'b1, "R2 done timing w32", {early, done32}, 64'b01);
    model(32, longint'(a), longint'(b), s, q, r);
    chk({hi32, lo32} === {r[31:0], q[31:0]}, tag_for(32, longint'(a), longint'(b), s),
        {hi32, lo32}, {r[31:0], q[31:0]});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [7:0] hold_snap;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy4, done4, hi4, lo4} === 10'd0, "R9 reset state", {busy4, done4, hi4, lo4}, 64'd0);
    chk({busy32, done32} === 2'd0 && {hi32, lo32} === 64'd0, "R9 reset state w32", {hi32, lo32}, 64'd0);

    op4(4'd6, 4'd2, 1'b0, 1'b0);
    chk({hi4, lo4} === 8'h03, "R10 6/2 unsigned", {hi4, lo4}, 64'h03);
    op4(4'd6, 4'd2, 1'b1, 1'b0);
    chk({hi4, lo4} === 8'h03, "R10 6/2 signed", {hi4, lo4}, 64'h03);

    // R8: a second start during the run must not disturb 13/3
    op4(4'd13, 4'd3, 1'b0, 1'b1);

    // R9: outputs hold while idle and inputs move
    hold_snap = {hi4, lo4};
    a4 = 4'd9; b4 = 4'd5; sg4 = 1'b1;
    repeat (3) @(negedge clk);
    chk({hi4, lo4} === hold_snap && done4 === 1'b0, "R9 hold while idle", {hi4, lo4}, hold_snap);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          op4(4'(a), 4'(b), 1'(s), 1'b0);

    op32(32'd100, 32'd7, 1'b0);
    op32(32'hFFFF_FFFF, 32'd1, 1'b0);
    op32(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0);
    op32(32'hDEAD_BEEF, 32'h0001_2345, 1'b0);
    op32(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    op32(-32'sd100, 32'd7, 1'b1);
    op32(32'd100, -32'sd7, 1'b1);
    op32(-32'sd100, -32'sd7, 1'b1);
    op32(32'h1234_5678, 32'd0, 1'b0);
    op32(32'h8000_0001, 32'd0, 1'b1);
    op32(32'h7000_0001, 32'd0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule